// File: doc/BRIEF.md
# Ring-Capable Stream-to-Memory DMA Engine

This block moves 32-bit words from an incoming valid/ready stream into memory. The destination buffers are described by a chain of 16-byte descriptors in memory. Each descriptor holds, by word: word 0 is the next-descriptor pointer, word 1 is the buffer address, word 2 is the buffer length in bytes (bits [25:0]), and word 3 is a status word that the engine writes back. The engine reads descriptors through a single-word read port, writes stream beats and status words through a single-word write port, and is controlled through four 32-bit registers. The register index is `reg_idx`. Index 0 is control, 1 is status, 2 is the current-descriptor pointer and 3 is the tail-descriptor pointer.

Software loads the first descriptor address into the current pointer while the channel is halted, then sets run, then writes the tail pointer. The tail write is what starts the descriptor walk. In normal mode the walk ends after the descriptor whose address equals the tail pointer. In ring mode the tail value only acts as the start event. The engine follows next-pointers forever, including the link from the last descriptor back to the first, until software clears run. Completion and error flags can drive two interrupt outputs, and each output is gated by its own enable bit.

Control bits are: bit 0 run, bit 1 ring mode, bit 2 completion-interrupt enable, bit 3 error-interrupt enable. Status bits are: bit 0 halted, bit 1 idle (running with no work pending), bit 2 completion flag, bit 3 error flag. Writing 1 to status bit 2 or bit 3 clears that flag.

Top module: `s2mm_ring_dma`

## Requirements
- R1: After reset the control register reads 0, status reads 0x1 (halted only), both interrupts are low, and `mrd_valid`, `mwr_valid` and `s_tready` are low.
- R2: Setting control bit 0 clears status bit 0 within three cycles, and clearing it sets status bit 0 again. While halted, no memory request is made and `s_tready` stays low.
- R3: A write to register 3 in normal mode starts the walk. The engine reads the descriptor at the current pointer at offsets 0, 4 and 8, and `s_tready` is low during these reads.
- R4: Stream beats are written to consecutive words starting at the buffer address, and the write address is always word aligned. A low `mwr_ready` holds the beat.
- R5: A descriptor ends when its length is filled or a beat carries `s_tlast`. The engine then writes 0x8000_0000 OR the transferred byte count to offset 12 of the descriptor. Words past the end of the data are left untouched.
- R6: In normal mode the walk stops after the descriptor equal to the tail pointer. Status bit 1 then reads 1, the current pointer reads that descriptor, and later descriptors are not written.
- R7: With control bit 1 set, the tail pointer is never a stop condition. The engine follows next-pointers around a closed ring, and the current pointer shows the descriptor in progress.
- R8: Status bit 2 is set at each completed descriptor. Writing 1 to it clears it. `irq_done` equals that flag ANDed with control bit 2.
- R9: A length of 0, a length or buffer address that is not a multiple of 4, or a descriptor pointer that is not a multiple of 16 sets status bit 3, halts the channel and clears control bit 0. `irq_err` equals status bit 3 ANDed with control bit 3, and writing 1 to status bit 3 clears the flag.
- R10: Clearing run while a descriptor is in its data phase abandons that descriptor without writing its status word, and the channel halts.
- R11: A write to register 2 while the channel is not halted is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index (0 control, 1 status, 2 current, 3 tail) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` (combinational) |
| irq_done | output | 1 | Completion interrupt |
| irq_err | output | 1 | Error interrupt |
| mrd_valid | output | 1 | Descriptor read request |
| mrd_addr | output | 32 | Descriptor read byte address |
| mrd_ready | input | 1 | Read data valid this cycle |
| mrd_rdata | input | 32 | Read data |
| mwr_valid | output | 1 | Memory write request |
| mwr_addr | output | 32 | Memory write byte address |
| mwr_data | output | 32 | Memory write data |
| mwr_ready | input | 1 | Memory write accepted |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| s_tdata | input | 32 | Stream data |
| s_tlast | input | 1 | Last beat of a packet |

## Verification
The hardest state to reach from the ports is a stop issued after the engine has wrapped around a ring and parked mid-way through a descriptor it has already completed once. At that point the status word in memory looks finished, so an illegal write-back would be invisible. The bench limits its stream source to exactly eight beats on a three-descriptor ring of two-beat buffers. This forces the engine to wrap, complete the first descriptor a second time and stall in the data phase of the second one. The bench then zeroes that descriptor's status word in its memory model and clears run, so any write-back shows up.

// File: rtl/dma_pkg.sv
package dma_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 26;

  // register indices
  localparam logic [1:0] RI_CTRL = 2'd0;
  localparam logic [1:0] RI_STAT = 2'd1;
  localparam logic [1:0] RI_CUR  = 2'd2;
  localparam logic [1:0] RI_TAIL = 2'd3;

  // control bit positions
  localparam int CB_RUN    = 0;
  localparam int CB_RING   = 1;
  localparam int CB_DONEEN = 2;
  localparam int CB_ERREN  = 3;

  // status bit positions
  localparam int SB_HALT = 0;
  localparam int SB_IDLE = 1;
  localparam int SB_DONE = 2;
  localparam int SB_ERR  = 3;

  typedef enum logic [2:0] {
    ST_HALT  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_FETCH = 3'd2,
    ST_XFER  = 3'd3,
    ST_WBACK = 3'd4
  } eng_st_t;

  // descriptors sit on 16-byte boundaries
  function automatic logic desc_ptr_ok(input logic [3:0] lo);
    return lo == 4'd0;
  endfunction

  // buffer address and length must be word multiples, length non-zero
  function automatic logic desc_body_bad(input logic [1:0] buf_lo,
                                         input logic [LEN_W-1:0] len);
    return (buf_lo != 2'd0) || (len == '0) || (len[1:0] != 2'd0);
  endfunction

  function automatic logic [31:0] status_word(input logic [LEN_W-1:0] bytes);
    return {1'b1, {(31-LEN_W){1'b0}}, bytes};
  endfunction

  function automatic logic desc_filled(input logic [LEN_W-1:0] bytes,
                                       input logic [LEN_W-1:0] len);
    return bytes >= len;
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_idx,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          eng_halted,
  input  logic          eng_idle,
  input  logic          ev_done,
  input  logic          ev_err,
  input  logic          cur_upd,
  input  logic [AW-1:0] cur_nxt,
  output logic          run,
  output logic          ring,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] tail_ptr,
  output logic          tail_kick,
  output logic          irq_done,
  output logic          irq_err
);

  logic done_en, err_en, done_f, err_f;
  logic wr_ctrl, wr_stat, wr_cur;

  assign wr_ctrl   = reg_wr && (reg_idx == RI_CTRL);
  assign wr_stat   = reg_wr && (reg_idx == RI_STAT);
  assign wr_cur    = reg_wr && (reg_idx == RI_CUR);
  assign tail_kick = reg_wr && (reg_idx == RI_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ring     <= 1'b0;
      done_en  <= 1'b0;
      err_en   <= 1'b0;
      done_f   <= 1'b0;
      err_f    <= 1'b0;
      cur_ptr  <= '0;
      tail_ptr <= '0;
    end else begin
      if (wr_ctrl) begin
        run     <= reg_wdata[CB_RUN];
        ring    <= reg_wdata[CB_RING];
        done_en <= reg_wdata[CB_DONEEN];
        err_en  <= reg_wdata[CB_ERREN];
      end
      if (ev_err) run <= 1'b0;

      if (ev_done)                          done_f <= 1'b1;
      else if (wr_stat && reg_wdata[SB_DONE]) done_f <= 1'b0;

      if (ev_err)                           err_f <= 1'b1;
      else if (wr_stat && reg_wdata[SB_ERR])  err_f <= 1'b0;

      if (cur_upd)                  cur_ptr <= cur_nxt;
      else if (wr_cur && eng_halted) cur_ptr <= AW'(reg_wdata);

      if (tail_kick) tail_ptr <= AW'(reg_wdata);
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_idx)
      RI_CTRL: reg_rdata = DW'({err_en, done_en, ring, run});
      RI_STAT: reg_rdata = DW'({err_f, done_f, eng_idle, eng_halted});
      RI_CUR:  reg_rdata = DW'(cur_ptr);
      default: reg_rdata = DW'(tail_ptr);
    endcase
  end

  assign irq_done = done_f & done_en;
  assign irq_err  = err_f & err_en;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ring,
  input  logic [AW-1:0] cur_ptr,
  input  logic [AW-1:0] tail_ptr,
  input  logic          tail_kick,
  output logic          mrd_valid,
  output logic [AW-1:0] mrd_addr,
  input  logic          mrd_ready,
  input  logic [DW-1:0] mrd_rdata,
  output logic          mwr_valid,
  output logic [AW-1:0] mwr_addr,
  output logic [DW-1:0] mwr_data,
  input  logic          mwr_ready,
  input  logic          s_tvalid,
  output logic          s_tready,
  input  logic [DW-1:0] s_tdata,
  input  logic          s_tlast,
  output logic          eng_halted,
  output logic          eng_idle,
  output logic          ev_done,
  output logic          ev_err,
  output logic          cur_upd,
  output logic [AW-1:0] cur_nxt,
  output logic          wb_phase
);

  localparam int          LW         = LEN_W;
  localparam int          BEAT_BYTES = DW / 8;
  localparam logic [AW-1:0] STAT_OFS = AW'(12);

  eng_st_t       st_q;
  logic          pend_q, pend_clr;
  logic [1:0]    idx_q;
  logic [AW-1:0] nxt_q, buf_q;
  logic [LW-1:0] len_q, cnt_q, cnt_inc;
  logic          fetch_on, xfer_on, wb_on;
  logic          fetch_hs, wb_hs, beat, fetch_bad, ring_end, last_beat;

  assign fetch_on = (st_q == ST_FETCH) && run;
  assign xfer_on  = (st_q == ST_XFER) && run;
  assign wb_on    = (st_q == ST_WBACK) && run;

  assign fetch_hs  = fetch_on && mrd_ready;
  assign wb_hs     = wb_on && mwr_ready;
  assign beat      = xfer_on && s_tvalid && mwr_ready;
  assign cnt_inc   = cnt_q + LW'(BEAT_BYTES);
  assign last_beat = s_tlast || desc_filled(cnt_inc, len_q);
  assign fetch_bad = desc_body_bad(buf_q[1:0], mrd_rdata[LW-1:0]);
  assign ring_end  = !ring && (cur_ptr == tail_ptr);

  assign mrd_valid = fetch_on;
  assign mrd_addr  = cur_ptr + AW'({idx_q, 2'b00});
  assign s_tready  = xfer_on && mwr_ready;
  assign mwr_valid = (xfer_on && s_tvalid) || wb_on;
  assign mwr_addr  = wb_on ? cur_ptr + STAT_OFS : buf_q + AW'(cnt_q);
  assign mwr_data  = wb_on ? DW'(status_word(cnt_q)) : s_tdata;

  assign ev_done = wb_hs;
  assign ev_err  = ((st_q == ST_WAIT) && run && pend_q && !desc_ptr_ok(cur_ptr[3:0]))
                || (fetch_hs && (idx_q == 2'd2) && fetch_bad)
                || (wb_hs && !ring_end && !desc_ptr_ok(nxt_q[3:0]));
  assign cur_upd = wb_hs && !ring_end;
  assign cur_nxt = nxt_q;

  assign eng_halted = (st_q == ST_HALT);
  assign eng_idle   = (st_q == ST_WAIT) && !pend_q;
  assign wb_phase   = (st_q == ST_WBACK);

  assign pend_clr = ((st_q != ST_HALT) && !run) || ((st_q == ST_WAIT) && run && pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HALT;
      pend_q <= 1'b0;
      idx_q  <= '0;
      nxt_q  <= '0;
      buf_q  <= '0;
      len_q  <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= tail_kick || (pend_q && !pend_clr);
      unique case (st_q)
        ST_HALT: if (run) st_q <= ST_WAIT;
        ST_WAIT: begin
          if (!run) st_q <= ST_HALT;
          else if (pend_q) begin
            if (desc_ptr_ok(cur_ptr[3:0])) begin
              st_q  <= ST_FETCH;
              idx_q <= '0;
            end else st_q <= ST_HALT;
          end
        end
        ST_FETCH: begin
          if (!run) st_q <= ST_HALT;
          else if (mrd_ready) begin
            idx_q <= idx_q + 2'd1;
            unique case (idx_q)
              2'd0:    nxt_q <= AW'(mrd_rdata);
              2'd1:    buf_q <= AW'(mrd_rdata);
              default: begin
                len_q <= mrd_rdata[LW-1:0];
                cnt_q <= '0;
                st_q  <= fetch_bad ? ST_HALT : ST_XFER;
              end
            endcase
          end
        end
        ST_XFER: begin
          if (!run) st_q <= ST_HALT;
          else if (beat) begin
            cnt_q <= cnt_inc;
            if (last_beat) st_q <= ST_WBACK;
          end
        end
        ST_WBACK: begin
          if (!run) st_q <= ST_HALT;
          else if (mwr_ready) begin
            if (ring_end) st_q <= ST_WAIT;
            else if (!desc_ptr_ok(nxt_q[3:0])) st_q <= ST_HALT;
            else begin
              st_q  <= ST_FETCH;
              idx_q <= '0;
            end
          end
        end
        default: st_q <= ST_HALT;
      endcase
    end
  end

endmodule

// File: rtl/s2mm_ring_dma.sv
module s2mm_ring_dma
  import dma_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_idx,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_done,
  output logic          irq_err,
  output logic          mrd_valid,
  output logic [AW-1:0] mrd_addr,
  input  logic          mrd_ready,
  input  logic [DW-1:0] mrd_rdata,
  output logic          mwr_valid,
  output logic [AW-1:0] mwr_addr,
  output logic [DW-1:0] mwr_data,
  input  logic          mwr_ready,
  input  logic          s_tvalid,
  output logic          s_tready,
  input  logic [DW-1:0] s_tdata,
  input  logic          s_tlast
);

  logic          run, ring, tail_kick;
  logic [AW-1:0] cur_ptr, tail_ptr, cur_nxt;
  logic          eng_halted, eng_idle, ev_done, ev_err, cur_upd, wb_phase;

  dma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_idx, .reg_wdata, .reg_rdata,
    .eng_halted, .eng_idle, .ev_done, .ev_err, .cur_upd, .cur_nxt,
    .run, .ring, .cur_ptr, .tail_ptr, .tail_kick, .irq_done, .irq_err
  );

  dma_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk, .rst_n, .run, .ring, .cur_ptr, .tail_ptr, .tail_kick,
    .mrd_valid, .mrd_addr, .mrd_ready, .mrd_rdata,
    .mwr_valid, .mwr_addr, .mwr_data, .mwr_ready,
    .s_tvalid, .s_tready, .s_tdata, .s_tlast,
    .eng_halted, .eng_idle, .ev_done, .ev_err, .cur_upd, .cur_nxt, .wb_phase
  );

endmodule

// File: rtl/dma_props.sv
module dma_props (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_halted,
  input logic       mrd_valid,
  input logic       mwr_valid,
  input logic       mwr_ready,
  input logic       s_tready,
  input logic [3:0] wr_lo,
  input logic       wr_flag,
  input logic       wb_phase,
  input logic       ev_done,
  input logic       ev_err
);

  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_halted |-> (!mrd_valid && !mwr_valid && !s_tready));

  p_no_tready_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid |-> !s_tready);

  p_wr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mwr_valid |-> (wr_lo[1:0] == 2'd0));

  p_wback_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |-> (wb_phase && mwr_valid && mwr_ready && wr_flag && wr_lo == 4'hC));

  p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> eng_halted);

endmodule

bind s2mm_ring_dma dma_props u_props (
  .clk(clk), .rst_n(rst_n), .eng_halted(eng_halted),
  .mrd_valid(mrd_valid), .mwr_valid(mwr_valid), .mwr_ready(mwr_ready),
  .s_tready(s_tready), .wr_lo(mwr_addr[3:0]), .wr_flag(mwr_data[DW-1]),
  .wb_phase(wb_phase), .ev_done(ev_done), .ev_err(ev_err)
);

// File: tb/sim_s2mm_ring_dma.sv
`timescale 1ns/1ps
module sim_s2mm_ring_dma;

  localparam int WD_CYC = 50000;
  localparam logic [31:0] SRC = 32'h1000_0000;
  // len bytes, tlast beat index (99 = none), write stall, expected bytes
  localparam int unsigned TBL [5][4] = '{
    '{16, 99, 0, 16},
    '{ 8, 99, 1,  8},
    '{32,  2, 0, 12},
    '{ 4, 99, 0,  4},
    '{24,  0, 1,  4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_done, irq_err;
  logic        mrd_valid, mwr_valid, s_tready;
  logic [31:0] mrd_addr, mwr_addr, mwr_data, mrd_rdata, s_tdata;
  logic        mwr_ready, s_tvalid, s_tlast;

  logic [31:0] mem [64];
  logic        h_we = 1'b0;
  logic [5:0]  h_a = '0;
  logic [31:0] h_d = '0;
  logic [7:0]  src_idx = '0;
  logic        src_clr = 1'b0;
  logic [7:0]  src_limit = '0;
  logic [7:0]  src_last = 8'd99;
  logic        stall_en = 1'b0;
  bit   [7:0]  tick;
  int          n_chk = 0, n_fail = 0;
  bit          wd_hit = 1'b0;

  always #4 clk = ~clk;

  assign mrd_rdata = mem[mrd_addr[7:2]];
  assign mwr_ready = stall_en ? tick[0] : 1'b1;
  assign s_tvalid  = src_idx < src_limit;
  assign s_tdata   = SRC + 32'(src_idx);
  assign s_tlast   = src_idx == src_last;

  always @(posedge clk) begin
    tick <= tick + 8'd1;
    if (h_we) mem[h_a] <= h_d;
    else if (mwr_valid && mwr_ready) mem[mwr_addr[7:2]] <= mwr_data;
    if (src_clr) src_idx <= '0;
    else if (s_tvalid && s_tready) src_idx <= src_idx + 8'd1;
  end

  s2mm_ring_dma u0 (
    .clk, .rst_n, .reg_wr, .reg_idx, .reg_wdata, .reg_rdata, .irq_done, .irq_err,
    .mrd_valid, .mrd_addr, .mrd_ready(1'b1), .mrd_rdata,
    .mwr_valid, .mwr_addr, .mwr_data, .mwr_ready,
    .s_tvalid, .s_tready, .s_tdata, .s_tlast
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rw(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rr(input logic [1:0] i, output logic [31:0] d);
    @(negedge clk); reg_idx = i; #1 d = reg_rdata;
  endtask

  task automatic mw(input int i, input logic [31:0] d);
    @(negedge clk); h_we = 1'b1; h_a = 6'(i); h_d = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic src_set(input int lim, input int last);
    @(negedge clk); src_clr = 1'b1; src_limit = 8'(lim); src_last = 8'(last);
    @(negedge clk); src_clr = 1'b0;
  endtask

  task automatic halt_now();
    rw(2'd0, 32'h0);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (4) @(negedge clk);
    for (int k = 0; k < 200; k++) begin
      rr(2'd1, s);
      if (s[1]) break;
    end
  endtask

  task automatic desc(input int w, input logic [31:0] nx, input logic [31:0] bf, input logic [31:0] ln);
    mw(w, nx); mw(w + 1, bf); mw(w + 2, ln); mw(w + 3, 32'h0);
  endtask

  task automatic tests();
    logic [31:0] v;
    // R1 reset state
    #1;
    chk("R1 mrd_valid", {31'b0, mrd_valid}, 32'h0);
    chk("R1 mwr_valid", {31'b0, mwr_valid}, 32'h0);
    chk("R1 s_tready", {31'b0, s_tready}, 32'h0);
    chk("R1 irqs", {30'b0, irq_done, irq_err}, 32'h0);
    rr(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rr(2'd1, v); chk("R1 stat", v, 32'h1);

    // R2 run clears halted, no kick yet so idle
    rw(2'd0, 32'h1);
    repeat (3) @(negedge clk);
    rr(2'd1, v); chk("R2 running stat", v & 32'h3, 32'h2);
    // R11 current pointer frozen while running
    rw(2'd2, 32'h30);
    rr(2'd2, v); chk("R11 cur ignored", v, 32'h0);
    halt_now();
    rr(2'd1, v); chk("R2 halted again", v & 32'h1, 32'h1);

    // table of single-descriptor transfers: R3 R4 R5 R8
    for (int r = 0; r < 5; r++) begin
      int nb;
      halt_now();
      desc(0, 32'h0, 32'h40, 32'(TBL[r][0]));
      for (int k = 16; k < 24; k++) mw(k, 32'hDEAD_0000 | 32'(k));
      rw(2'd2, 32'h0);
      stall_en = TBL[r][2][0];
      src_set(64, int'(TBL[r][1]));
      rw(2'd0, 32'h5);
      rw(2'd3, 32'h0);
      wait_idle();
      nb = int'(TBL[r][3]) / 4;
      chk($sformatf("R5 status word row%0d", r), mem[3], 32'h8000_0000 | 32'(TBL[r][3]));
      for (int k = 0; k < nb; k++)
        chk($sformatf("R4 data row%0d w%0d", r, k), mem[16 + k], SRC + 32'(k));
      if (nb < int'(TBL[r][0]) / 4 || nb < 8)
        chk($sformatf("R5 untouched row%0d", r), mem[16 + nb], 32'hDEAD_0000 | 32'(16 + nb));
      chk($sformatf("R3 beats taken row%0d", r), {24'b0, src_idx}, 32'(nb));
      rr(2'd1, v); chk($sformatf("R8 done flag row%0d", r), v & 32'h4, 32'h4);
      chk("R8 irq_done enabled", {31'b0, irq_done}, 32'h1);
      rw(2'd1, 32'h4);
      rr(2'd1, v); chk("R8 done W1C", v & 32'h4, 32'h0);
      chk("R8 irq_done cleared", {31'b0, irq_done}, 32'h0);
    end
    stall_en = 1'b0;

    // R6 normal chain stops at tail
    halt_now();
    desc(0, 32'h10, 32'h40, 32'h8);
    desc(4, 32'h20, 32'h60, 32'h8);
    desc(8, 32'h00, 32'h80, 32'h8);
    rw(2'd2, 32'h0);
    src_set(64, 99);
    rw(2'd0, 32'h1);
    rw(2'd3, 32'h10);
    wait_idle();
    chk("R6 first status", mem[3], 32'h8000_0008);
    chk("R6 tail status", mem[7], 32'h8000_0008);
    chk("R6 beyond tail untouched", mem[11], 32'h0);
    chk("R6 second buffer", mem[25], SRC + 32'd3);
    rr(2'd2, v); chk("R6 cur at tail", v, 32'h10);
    rr(2'd1, v); chk("R6 idle", v & 32'h3, 32'h2);
    chk("R8 irq_done masked", {31'b0, irq_done}, 32'h0);

    // R7 ring mode wraps, R10 abandon on stop
    halt_now();
    mw(3, 32'h0); mw(7, 32'h0); mw(11, 32'h0);
    rw(2'd2, 32'h0);
    src_set(8, 99);
    rw(2'd0, 32'h3);
    rw(2'd3, 32'hF0);
    repeat (60) @(negedge clk);
    chk("R7 wrapped into first buffer", mem[16], SRC + 32'd6);
    chk("R7 wrapped second word", mem[17], SRC + 32'd7);
    chk("R7 last descriptor done", mem[11], 32'h8000_0008);
    rr(2'd2, v); chk("R7 cur shows in-progress", v, 32'h10);
    rr(2'd1, v); chk("R7 busy not idle", v & 32'h3, 32'h0);
    mw(7, 32'h0);
    rw(2'd0, 32'h2);
    repeat (5) @(negedge clk);
    rr(2'd1, v); chk("R10 halted after stop", v & 32'h1, 32'h1);
    chk("R10 no status write", mem[7], 32'h0);
    chk("R2 no tready halted", {31'b0, s_tready}, 32'h0);

    // R9 zero length, error irq enabled
    halt_now();
    desc(0, 32'h0, 32'h40, 32'h0);
    rw(2'd2, 32'h0);
    rw(2'd0, 32'h9);
    rw(2'd3, 32'h0);
    repeat (10) @(negedge clk);
    rr(2'd1, v); chk("R9 zero len err+halt", v & 32'hB, 32'h9);
    chk("R9 irq_err", {31'b0, irq_err}, 32'h1);
    rr(2'd0, v); chk("R9 run cleared", v & 32'h1, 32'h0);
    rw(2'd1, 32'h8);
    rr(2'd1, v); chk("R9 err W1C", v & 32'h8, 32'h0);
    chk("R9 irq_err cleared", {31'b0, irq_err}, 32'h0);

    // R9 unaligned buffer, irq disabled
    desc(0, 32'h0, 32'h42, 32'h8);
    rw(2'd0, 32'h1);
    rw(2'd3, 32'h0);
    repeat (10) @(negedge clk);
    rr(2'd1, v); chk("R9 unaligned buf err", v & 32'h9, 32'h9);
    chk("R9 irq_err masked", {31'b0, irq_err}, 32'h0);
    rw(2'd1, 32'h8);

    // R9 unaligned descriptor pointer
    rw(2'd2, 32'h4);
    rw(2'd0, 32'h9);
    rw(2'd3, 32'h4);
    repeat (10) @(negedge clk);
    rr(2'd1, v); chk("R9 bad desc ptr", v & 32'h9, 32'h9);
    chk("R9 irq_err ptr", {31'b0, irq_err}, 32'h1);
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      tests();
      begin repeat (WD_CYC) @(posedge clk); wd_hit = 1'b1; end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule